// File: doc/BRIEF.md
# Cache Forward-Progress Guard

This block sits beside a cache controller and keeps a freshly delivered line from being taken away before the local core has used it. Without such a guard, two caches can pass one line back and forth indefinitely with neither doing useful work. The guard tracks a small number of line slots. A fill from the directory marks its slot as waiting for first use. An invalidation or recall that arrives while the slot waits is parked, and its acknowledgement goes out only after the core has made one access of the qualifying kind. A shared fill needs a load. A modified fill needs a store.

The guard also arbitrates between the directory and the core for each slot. When a directory message (fill or invalidation) targets a slot in the same cycle as a core access to that slot, the core access is refused and must be presented again. Negative acknowledgements from the directory arm a per-slot retry timer. When the timer runs out, the guard presents the original request again, with its slot and store flag.

Top module: `fpg_guard`

## Requirements
- R1: After reset no slot is waiting for use, no invalidation is parked, `ack_valid` and `reissue_valid` are 0, and a lone core request is granted in the same cycle.
- R2: An invalidation for a slot that is waiting for first use produces no acknowledgement while that use has not happened.
- R3: For a shared fill (`fill_modified`=0), a granted load in cycle t releases the parked invalidation: `ack_valid`=1 with that slot in cycle t+2 only.
- R4: For a modified fill (`fill_modified`=1), a granted load does not release the parked invalidation. A granted store in cycle t does, and the acknowledgement appears in cycle t+2.
- R5: An invalidation in cycle t for a slot that is not waiting for use is acknowledged in cycle t+2, for one cycle.
- R6: `core_grant` is 0 in any cycle where a fill or an invalidation targets the same slot as the core request. A refused access does not count as the slot's first use.
- R7: `ack_data` is 1 when the acknowledged slot was last filled as modified (data returned) and 0 when it was filled as shared.
- R8: A NACK in cycle t for a slot makes `reissue_valid`=1 in cycle t+8 for one cycle, with `reissue_slot` and `reissue_store` equal to the NACKed values. Before that cycle the output is 0.
- R9: When several slots are ready to be acknowledged in the same cycle, the acknowledgements go out one per cycle, lowest slot index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | Directory fill for a slot |
| fill_slot | input | SLOT_W | Slot being filled |
| fill_modified | input | 1 | 1 = fill in modified state, 0 = shared |
| inv_valid | input | 1 | Directory invalidation or recall |
| inv_slot | input | SLOT_W | Slot targeted by the invalidation |
| core_req_valid | input | 1 | Core pipeline access presented |
| core_req_slot | input | SLOT_W | Slot of the core access |
| core_req_store | input | 1 | 1 = store, 0 = load |
| core_grant | output | 1 | Core access accepted this cycle |
| ack_valid | output | 1 | Invalidation reply to the directory |
| ack_slot | output | SLOT_W | Slot of the reply |
| ack_data | output | 1 | Reply carries modified data |
| nack_valid | input | 1 | Directory refused a request |
| nack_slot | input | SLOT_W | Slot of the refused request |
| nack_store | input | 1 | Refused request was a store |
| reissue_valid | output | 1 | Request presented again |
| reissue_slot | output | SLOT_W | Slot of the reissued request |
| reissue_store | output | 1 | Reissued request is a store |

## Verification
The parking rule is tried with four access patterns on the waiting slot: a load after a shared fill, and a load and then a store after a modified fill. These separate a guard that accepts any access from one that matches the access kind to the fill kind. The fourth pattern is a load refused by a same-slot invalidation in the same cycle, which shows whether a refused access is wrongly counted as the first use. An invalidation to an idle slot checks the release latency without parking. Two slots that become ready in the same cycle show the order of the replies. NACKs are checked for the exact reissue cycle and for the stored flags.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
    localparam int DEFAULT_SLOTS = 4;
    localparam int DEFAULT_RETRY = 8;

    typedef enum logic {
        FILL_SHARED   = 1'b0,
        FILL_MODIFIED = 1'b1
    } fill_kind_e;

    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_kind_e;

    // Does an access of this kind count as first use of a line filled this way?
    function automatic logic qualifies(fill_kind_e fk, acc_kind_e ak);
        return (fk == FILL_MODIFIED) ? (ak == ACC_STORE) : (ak == ACC_LOAD);
    endfunction
endpackage

// File: rtl/fpg_pick.sv
module fpg_pick #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/fpg_slot.sv
module fpg_slot
    import fpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fill_hit,
    input  fill_kind_e fill_kind,
    input  logic       use_hit,
    input  acc_kind_e  use_kind,
    input  logic       inv_hit,
    input  logic       release_hit,
    output logic       pending,
    output logic       held,
    output fill_kind_e kind
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            held    <= 1'b0;
            kind    <= FILL_SHARED;
        end else begin
            if (fill_hit) begin
                pending <= 1'b1;
                kind    <= fill_kind;
            end else if (use_hit && qualifies(kind, use_kind)) begin
                pending <= 1'b0;
            end
            if (inv_hit)
                held <= 1'b1;
            else if (release_hit)
                held <= 1'b0;
        end
    end
endmodule

// File: rtl/fpg_retry.sv
module fpg_retry #(
    parameter int N     = 4,
    parameter int DELAY = 8,
    localparam int W    = (N > 1) ? $clog2(N) : 1,
    localparam int CW   = $clog2(DELAY + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         nack_valid,
    input  logic [W-1:0] nack_slot,
    input  logic         nack_store,
    output logic         reissue_valid,
    output logic [W-1:0] reissue_slot,
    output logic         reissue_store
);
    logic [N-1:0] armed;
    logic [N-1:0] store_q;
    logic [N-1:0] due;
    logic [CW-1:0] cnt [N];

    fpg_pick #(.N(N)) u_pick (.req(due), .any(reissue_valid), .idx(reissue_slot));

    assign reissue_store = store_q[reissue_slot];

    for (genvar i = 0; i < N; i++) begin : g_tmr
        assign due[i] = armed[i] && (cnt[i] == '0);
        always_ff @(posedge clk) begin
            if (rst) begin
                armed[i]   <= 1'b0;
                store_q[i] <= 1'b0;
                cnt[i]     <= '0;
            end else if (nack_valid && nack_slot == W'(i)) begin
                armed[i]   <= 1'b1;
                store_q[i] <= nack_store;
                cnt[i]     <= CW'(DELAY - 1);
            end else if (armed[i] && cnt[i] != '0) begin
                cnt[i] <= cnt[i] - 1'b1;
            end else if (due[i] && reissue_slot == W'(i)) begin
                armed[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fpg_guard.sv
module fpg_guard
    import fpg_pkg::*;
#(
    parameter int NUM_SLOTS    = DEFAULT_SLOTS,
    parameter int RETRY_CYCLES = DEFAULT_RETRY,
    localparam int SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_valid,
    input  logic [SLOT_W-1:0] fill_slot,
    input  logic              fill_modified,
    input  logic              inv_valid,
    input  logic [SLOT_W-1:0] inv_slot,
    input  logic              core_req_valid,
    input  logic [SLOT_W-1:0] core_req_slot,
    input  logic              core_req_store,
    output logic              core_grant,
    output logic              ack_valid,
    output logic [SLOT_W-1:0] ack_slot,
    output logic              ack_data,
    input  logic              nack_valid,
    input  logic [SLOT_W-1:0] nack_slot,
    input  logic              nack_store,
    output logic              reissue_valid,
    output logic [SLOT_W-1:0] reissue_slot,
    output logic              reissue_store
);
    logic [NUM_SLOTS-1:0] pending_vec;
    logic [NUM_SLOTS-1:0] held_vec;
    logic [NUM_SLOTS-1:0] modified_vec;
    logic [NUM_SLOTS-1:0] ready_vec;
    logic                 rel_any;
    logic [SLOT_W-1:0]    rel_idx;

    // Directory traffic to a slot wins over the core in the same cycle.
    assign core_grant = core_req_valid
                     && !(fill_valid && fill_slot == core_req_slot)
                     && !(inv_valid  && inv_slot  == core_req_slot);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        fill_kind_e kind_w;
        fpg_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .fill_hit   (fill_valid && fill_slot == SLOT_W'(i)),
            .fill_kind  (fill_kind_e'(fill_modified)),
            .use_hit    (core_grant && core_req_slot == SLOT_W'(i)),
            .use_kind   (acc_kind_e'(core_req_store)),
            .inv_hit    (inv_valid && inv_slot == SLOT_W'(i)),
            .release_hit(rel_any && rel_idx == SLOT_W'(i)),
            .pending    (pending_vec[i]),
            .held       (held_vec[i]),
            .kind       (kind_w)
        );
        assign modified_vec[i] = (kind_w == FILL_MODIFIED);
        assign ready_vec[i]    = held_vec[i] && !pending_vec[i];
    end

    fpg_pick #(.N(NUM_SLOTS)) u_rel (.req(ready_vec), .any(rel_any), .idx(rel_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_valid <= 1'b0;
            ack_slot  <= '0;
            ack_data  <= 1'b0;
        end else begin
            ack_valid <= rel_any;
            ack_slot  <= rel_idx;
            ack_data  <= modified_vec[rel_idx];
        end
    end

    fpg_retry #(.N(NUM_SLOTS), .DELAY(RETRY_CYCLES)) u_retry (
        .clk          (clk),
        .rst          (rst),
        .nack_valid   (nack_valid),
        .nack_slot    (nack_slot),
        .nack_store   (nack_store),
        .reissue_valid(reissue_valid),
        .reissue_slot (reissue_slot),
        .reissue_store(reissue_store)
    );
endmodule

// File: rtl/fpg_guard_chk.sv
module fpg_guard_chk #(
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 fill_valid,
    input logic [SLOT_W-1:0]    fill_slot,
    input logic                 inv_valid,
    input logic [SLOT_W-1:0]    inv_slot,
    input logic                 core_req_valid,
    input logic [SLOT_W-1:0]    core_req_slot,
    input logic                 core_req_store,
    input logic                 core_grant,
    input logic                 ack_valid,
    input logic                 nack_valid,
    input logic [SLOT_W-1:0]    nack_slot,
    input logic                 reissue_valid,
    input logic [SLOT_W-1:0]    reissue_slot,
    input logic [NUM_SLOTS-1:0] pending_vec,
    input logic [NUM_SLOTS-1:0] modified_vec
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!ack_valid && !reissue_valid && pending_vec == '0));

    // R6
    dir_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (core_req_valid && ((inv_valid && inv_slot == core_req_slot)
                         || (fill_valid && fill_slot == core_req_slot))) |-> !core_grant);

    // R4
    mod_load_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (core_grant && !core_req_store && modified_vec[core_req_slot]
         && pending_vec[core_req_slot]) |=> pending_vec[$past(core_req_slot)]);

    // R3
    shared_load_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (core_grant && !core_req_store && !modified_vec[core_req_slot]
         && pending_vec[core_req_slot]) |=> !pending_vec[$past(core_req_slot)]);

    // R8
    no_early_reissue_chk: assert property (@(posedge clk) disable iff (rst)
        (reissue_valid && $past(nack_valid)) |-> ($past(nack_slot) != reissue_slot));
endmodule

bind fpg_guard fpg_guard_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .fill_valid    (fill_valid),
    .fill_slot     (fill_slot),
    .inv_valid     (inv_valid),
    .inv_slot      (inv_slot),
    .core_req_valid(core_req_valid),
    .core_req_slot (core_req_slot),
    .core_req_store(core_req_store),
    .core_grant    (core_grant),
    .ack_valid     (ack_valid),
    .nack_valid    (nack_valid),
    .nack_slot     (nack_slot),
    .reissue_valid (reissue_valid),
    .reissue_slot  (reissue_slot),
    .pending_vec   (pending_vec),
    .modified_vec  (modified_vec)
);

// File: tb/fpg_guard_test.sv
`timescale 1ns/1ps
module fpg_guard_test;
    localparam int N  = 4;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fill_valid = 0, fill_modified = 0, inv_valid = 0;
    logic core_req_valid = 0, core_req_store = 0, nack_valid = 0, nack_store = 0;
    logic [SW-1:0] fill_slot = 0, inv_slot = 0, core_req_slot = 0, nack_slot = 0;
    logic core_grant, ack_valid, ack_data, reissue_valid, reissue_store;
    logic [SW-1:0] ack_slot, reissue_slot;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fpg_guard #(.NUM_SLOTS(N), .RETRY_CYCLES(8)) uut (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        fill_valid = 0; inv_valid = 0; core_req_valid = 0; nack_valid = 0;
        fill_modified = 0; core_req_store = 0; nack_store = 0;
    endtask

    task automatic step();
        @(negedge clk);
        idle();
    endtask

    // Ack word: {valid, data, slot}
    function automatic logic [7:0] ackw();
        return {4'b0, ack_valid, ack_data, ack_slot};
    endfunction

    task automatic t_reset();
        check("R1 ack idle", {7'b0, ack_valid}, 8'd0);
        check("R1 reissue idle", {7'b0, reissue_valid}, 8'd0);
        core_req_valid = 1; core_req_slot = 2; core_req_store = 0;
        #1 check("R1 lone grant", {7'b0, core_grant}, 8'd1);
        step();
    endtask

    task automatic t_shared();
        fill_valid = 1; fill_slot = 1; fill_modified = 0;
        step();
        inv_valid = 1; inv_slot = 1;
        step();
        for (int k = 0; k < 4; k++) begin
            check("R2 no ack while waiting", {7'b0, ack_valid}, 8'd0);
            step();
        end
        core_req_valid = 1; core_req_slot = 1; core_req_store = 0;
        #1 check("R3 load granted", {7'b0, core_grant}, 8'd1);
        step();
        check("R3 ack not yet", {7'b0, ack_valid}, 8'd0);
        step();
        check("R3 R7 ack shared", ackw(), {4'b0, 1'b1, 1'b0, 2'd1});
        step();
        check("R3 ack one cycle", {7'b0, ack_valid}, 8'd0);
    endtask

    task automatic t_modified();
        fill_valid = 1; fill_slot = 2; fill_modified = 1;
        step();
        inv_valid = 1; inv_slot = 2;
        step();
        core_req_valid = 1; core_req_slot = 2; core_req_store = 0;
        step();
        for (int k = 0; k < 4; k++) begin
            check("R4 load does not release", {7'b0, ack_valid}, 8'd0);
            step();
        end
        core_req_valid = 1; core_req_slot = 2; core_req_store = 1;
        step();
        check("R4 ack not yet", {7'b0, ack_valid}, 8'd0);
        step();
        check("R4 R7 ack modified", ackw(), {4'b0, 1'b1, 1'b1, 2'd2});
        step();
    endtask

    task automatic t_idle_inv();
        inv_valid = 1; inv_slot = 3;
        step();
        check("R5 ack not yet", {7'b0, ack_valid}, 8'd0);
        step();
        check("R5 idle ack", {4'b0, ack_valid, 1'b0, ack_slot}, {4'b0, 1'b1, 1'b0, 2'd3});
        step();
        check("R5 ack one cycle", {7'b0, ack_valid}, 8'd0);
    endtask

    task automatic t_priority();
        fill_valid = 1; fill_slot = 0; fill_modified = 0;
        core_req_valid = 1; core_req_slot = 0;
        #1 check("R6 fill beats core", {7'b0, core_grant}, 8'd0);
        step();
        inv_valid = 1; inv_slot = 0;
        core_req_valid = 1; core_req_slot = 0; core_req_store = 0;
        #1 check("R6 inv beats core", {7'b0, core_grant}, 8'd0);
        step();
        for (int k = 0; k < 4; k++) begin
            check("R6 refused load not counted", {7'b0, ack_valid}, 8'd0);
            step();
        end
        core_req_valid = 1; core_req_slot = 0;
        step();
        step();
        check("R6 ack after real load", {4'b0, ack_valid, 1'b0, ack_slot}, {4'b0, 1'b1, 1'b0, 2'd0});
        step();
    endtask

    task automatic t_order();
        fill_valid = 1; fill_slot = 3; fill_modified = 0;
        step();
        inv_valid = 1; inv_slot = 3;
        step();
        // load on slot 3 and invalidate idle slot 0 in the same cycle
        core_req_valid = 1; core_req_slot = 3;
        inv_valid = 1; inv_slot = 0;
        step();
        step();
        check("R9 lower slot first", {4'b0, ack_valid, 1'b0, ack_slot}, {4'b0, 1'b1, 1'b0, 2'd0});
        step();
        check("R9 higher slot next", {4'b0, ack_valid, 1'b0, ack_slot}, {4'b0, 1'b1, 1'b0, 2'd3});
        step();
        check("R9 drained", {7'b0, ack_valid}, 8'd0);
    endtask

    task automatic t_retry();
        nack_valid = 1; nack_slot = 2; nack_store = 1;
        step();
        for (int k = 1; k < 8; k++) begin
            check("R8 no early reissue", {7'b0, reissue_valid}, 8'd0);
            step();
        end
        check("R8 reissue at 8", {4'b0, reissue_valid, reissue_store, reissue_slot},
              {4'b0, 1'b1, 1'b1, 2'd2});
        step();
        check("R8 reissue one cycle", {7'b0, reissue_valid}, 8'd0);
        nack_valid = 1; nack_slot = 1; nack_store = 0;
        step();
        for (int k = 1; k < 8; k++) step();
        check("R8 load reissue", {4'b0, reissue_valid, reissue_store, reissue_slot},
              {4'b0, 1'b1, 1'b0, 2'd1});
        step();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        step();
        t_reset();
        t_shared();
        t_modified();
        t_idle_inv();
        t_priority();
        t_order();
        t_retry();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule